// File: doc/BRIEF.md
# ISA Command Cycle Timer

This block sits between a host-side request port and the ISA command lines. It turns each accepted request into one command strobe: I/O read, I/O write, memory read or memory write. The strobe is held for a programmed number of bus clocks. A bus-clock enable, generated inside the block, paces everything. That enable is either a fixed fraction of the system (PCI) clock or a retimed copy of an external reference tick. The choice comes from a clock-select byte.

A timing byte sets the wait states and the I/O recovery gap. The 8-bit and 16-bit cycles use separate fields. The block latches the relevant settings at the start of each command. When a command ends, the block returns a one-cycle done pulse.

The host holds `req_i` with its attributes steady until it sees `done_o`. It may keep `req_i` high to queue a follow-on command, changing the attributes in the cycle where `done_o` is high.

Top module: `isa_cycle_timer`

## Requirements
- R1: Clock-select bits [7:6] = 01 give one `bclk_en_o` pulse every 4 clocks, and 10 give one every 3 clocks.
- R2: Clock-select bits [7:6] = 00 make `bclk_en_o` follow `ref_tick_i` one clock later. The reserved code 11 behaves exactly like 00.
- R3: A 16-bit command holds its strobe for 1 + W bus clocks. W is 2 when timing bit 2 is 0 and 1 when it is 1.
- R4: An 8-bit command holds its strobe for 1 + W bus clocks. W is 5 when timing bit 1 is 0 and 4 when it is 1.
- R5: After a 16-bit I/O strobe falls, the next I/O strobe rises no sooner than N bus clocks later, and exactly N later when already requested. N comes from timing bits [7:6]: 00=5, 01=4, 10=3, 11=2.
- R6: After an 8-bit I/O strobe falls, the next I/O strobe follows the same rule with N from timing bits [5:4]: 00=8, 01=5, 10=4, 11=3.
- R7: Memory commands ignore the recovery gap. A pending memory command starts on the first bus clock after the previous strobe falls, and a memory command loads no recovery gap.
- R8: Exactly one strobe is raised per command, chosen by `req_io_i` and `req_write_i`:
  - I/O read raises `io_rd_o`.
  - I/O write raises `io_wr_o`.
  - Memory read raises `mem_rd_o`.
  - Memory write raises `mem_wr_o`.
- R9: `done_o` is high for exactly one clock, in the first clock where the strobe is low again.
- R10: Timing settings are captured when a command starts. Changing the timing byte during a command does not alter that command's length or the recovery gap that follows it.
- R11: While and right after the synchronous reset, all strobes and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System (PCI) clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_cfg_i | input | 8 | Clock-select byte; bits [7:6] pick the bus-clock source |
| tim_cfg_i | input | 8 | Timing byte: [7:6] 16-bit recovery, [5:4] 8-bit recovery, [2] 16-bit wait, [1] 8-bit wait |
| ref_tick_i | input | 1 | One-clock pulse from the fixed reference clock |
| req_i | input | 1 | Command request, held until done |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| io_rd_o | output | 1 | I/O read strobe, active high |
| io_wr_o | output | 1 | I/O write strobe, active high |
| mem_rd_o | output | 1 | Memory read strobe, active high |
| mem_wr_o | output | 1 | Memory write strobe, active high |
| bclk_en_o | output | 1 | Bus-clock enable pulse |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A wrong wait-state or divider count shows up in the first command as a strobe that is one or more bus clocks too long or too short. A stale or mis-loaded recovery counter shows up only on the second command of a back-to-back pair, as a low gap of the wrong length. A sequencer stuck in its active state leaves the strobe high and withholds `done_o`. The bench therefore measures every strobe length and every inter-command gap in clocks, and compares each against a value derived from the field encodings.

// File: rtl/isa_tmg_pkg.sv
package isa_tmg_pkg;

    localparam int unsigned TMG_CNT_W = 4;
    localparam int unsigned TMG_DIV_W = 2;

    typedef enum logic [1:0] {
        BCLK_REF   = 2'b00,
        BCLK_QTR   = 2'b01,
        BCLK_THIRD = 2'b10,
        BCLK_RSVD  = 2'b11
    } bclk_sel_e;

    typedef struct packed {
        logic is_io;
        logic is_write;
        logic is_wide;
    } req_attr_t;

    typedef struct packed {
        logic io_rd;
        logic io_wr;
        logic mem_rd;
        logic mem_wr;
    } cmd_strb_t;

    typedef struct packed {
        logic [1:0] rec16;
        logic [1:0] rec8;
        logic       ws16_fast;
        logic       ws8_fast;
    } tim_fields_t;

    function automatic tim_fields_t unpack_tim(input logic [7:0] b);
        tim_fields_t f;
        f.rec16     = b[7:6];
        f.rec8      = b[5:4];
        f.ws16_fast = b[2];
        f.ws8_fast  = b[1];
        return f;
    endfunction

    // Number of wait states for a command of the given width.
    function automatic int unsigned wait_states(input logic wide, input tim_fields_t f);
        if (wide) return f.ws16_fast ? 1 : 2;
        return f.ws8_fast ? 4 : 5;
    endfunction

    // Recovery gap in bus clocks after an I/O command of the given width.
    function automatic int unsigned recovery_clocks(input logic wide, input tim_fields_t f);
        if (wide) return 5 - int'(f.rec16);
        case (f.rec8)
            2'b00:   return 8;
            2'b01:   return 5;
            2'b10:   return 4;
            default: return 3;
        endcase
    endfunction

    function automatic cmd_strb_t strobe_for(input req_attr_t a);
        cmd_strb_t s;
        s.io_rd  = a.is_io  & ~a.is_write;
        s.io_wr  = a.is_io  &  a.is_write;
        s.mem_rd = ~a.is_io & ~a.is_write;
        s.mem_wr = ~a.is_io &  a.is_write;
        return s;
    endfunction

endpackage

// File: rtl/isa_bclk_gen.sv
module isa_bclk_gen
    import isa_tmg_pkg::*;
#(
    parameter int unsigned DIV_W = TMG_DIV_W
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  bclk_sel_e sel_i,
    input  logic      ref_tick_i,
    output logic      tick_o
);
    localparam logic [DIV_W-1:0] QTR_LAST   = DIV_W'(3);
    localparam logic [DIV_W-1:0] THIRD_LAST = DIV_W'(2);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             use_ref;
    logic             tick_q;

    always_comb begin
        use_ref = 1'b0;
        last    = QTR_LAST;
        case (sel_i)
            BCLK_QTR:   last = QTR_LAST;
            BCLK_THIRD: last = THIRD_LAST;
            default:    use_ref = 1'b1;   // reserved code falls back to the reference
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (use_ref) begin
            cnt_q  <= '0;
            tick_q <= ref_tick_i;
        end else if (cnt_q >= last) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_q && !use_ref) |=> (!tick_q || use_ref)); // R1
    AST_REF_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (use_ref && $past(use_ref) && !$past(rst_i)) |-> (tick_q == $past(ref_tick_i))); // R2
endmodule

// File: rtl/isa_rec_timer.sv
module isa_rec_timer
    import isa_tmg_pkg::*;
#(
    parameter int unsigned CNT_W = TMG_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             idle_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                      cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign idle_o = (cnt_q == '0);

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> idle_o); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !tick_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/isa_cmd_seq.sv
module isa_cmd_seq
    import isa_tmg_pkg::*;
#(
    parameter int unsigned CNT_W = TMG_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             req_i,
    input  req_attr_t        attr_i,
    input  tim_fields_t      tim_i,
    input  logic             rec_idle_i,
    output cmd_strb_t        strb_o,
    output logic             done_o,
    output logic             rec_load_o,
    output logic [CNT_W-1:0] rec_val_o
);
    typedef enum logic {ST_IDLE, ST_ACT} seq_state_e;

    seq_state_e       state_q;
    req_attr_t        attr_q;
    logic [CNT_W-1:0] ws_q;
    logic [CNT_W-1:0] rec_q;
    logic [CNT_W-1:0] cnt_q;
    cmd_strb_t        strb_q;
    logic             done_q;
    logic             start;
    logic             finish;
    logic             busy;

    assign busy   = (state_q == ST_ACT);
    assign start  = !busy && req_i && tick_i && (!attr_i.is_io || rec_idle_i);
    assign finish = busy && tick_i && (cnt_q == ws_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
            ws_q    <= '0;
            rec_q   <= '0;
            cnt_q   <= '0;
            strb_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q <= ST_ACT;
                attr_q  <= attr_i;
                ws_q    <= CNT_W'(wait_states(attr_i.is_wide, tim_i));
                rec_q   <= CNT_W'(recovery_clocks(attr_i.is_wide, tim_i));
                cnt_q   <= '0;
                strb_q  <= strobe_for(attr_i);
            end else if (finish) begin
                state_q <= ST_IDLE;
                strb_q  <= '0;
                done_q  <= 1'b1;
            end else if (busy && tick_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The gap is counted from the fall, so one bus clock is already covered
    // by the start condition itself.
    assign rec_load_o = finish && attr_q.is_io;
    assign rec_val_o  = rec_q - 1'b1;
    assign strb_o     = strb_q;
    assign done_o     = done_q;

    AST_STRB_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(strb_q)); // R8
    AST_BUSY_HAS_STRB: assert property (@(posedge clk_i) disable iff (rst_i)
        busy |-> $countones(strb_q) == 1); // R8
    AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy != $past(busy)) |-> $past(tick_i)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        busy |-> (cnt_q <= ws_q)); // R4
    AST_IO_AFTER_REC: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(busy) && attr_q.is_io) |-> $past(rec_idle_i)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> !done_q); // R9
    AST_ATTR_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy && $past(busy)) |-> $stable(attr_q) && $stable(ws_q)); // R10
endmodule

// File: rtl/isa_cycle_timer.sv
module isa_cycle_timer
    import isa_tmg_pkg::*;
#(
    parameter int unsigned CNT_W = TMG_CNT_W,
    parameter int unsigned DIV_W = TMG_DIV_W
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [7:0] bclk_cfg_i,
    input  logic [7:0] tim_cfg_i,
    input  logic       ref_tick_i,
    input  logic       req_i,
    input  logic       req_io_i,
    input  logic       req_write_i,
    input  logic       req_wide_i,
    output logic       io_rd_o,
    output logic       io_wr_o,
    output logic       mem_rd_o,
    output logic       mem_wr_o,
    output logic       bclk_en_o,
    output logic       done_o
);
    bclk_sel_e        sel;
    tim_fields_t      tim;
    req_attr_t        attr;
    cmd_strb_t        strb;
    logic             tick;
    logic             rec_idle;
    logic             rec_load;
    logic [CNT_W-1:0] rec_val;
    logic             unused_cfg;

    assign sel        = bclk_sel_e'(bclk_cfg_i[7:6]);
    assign tim        = unpack_tim(tim_cfg_i);
    assign attr       = '{is_io: req_io_i, is_write: req_write_i, is_wide: req_wide_i};
    assign unused_cfg = ^{bclk_cfg_i[5:0], tim_cfg_i[3], tim_cfg_i[0]};

    isa_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sel_i      (sel),
        .ref_tick_i (ref_tick_i),
        .tick_o     (tick)
    );

    isa_rec_timer #(.CNT_W(CNT_W)) u_rec (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick),
        .load_i     (rec_load),
        .load_val_i (rec_val),
        .idle_o     (rec_idle)
    );

    isa_cmd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick),
        .req_i      (req_i),
        .attr_i     (attr),
        .tim_i      (tim),
        .rec_idle_i (rec_idle),
        .strb_o     (strb),
        .done_o     (done_o),
        .rec_load_o (rec_load),
        .rec_val_o  (rec_val)
    );

    assign io_rd_o   = strb.io_rd;
    assign io_wr_o   = strb.io_wr;
    assign mem_rd_o  = strb.mem_rd;
    assign mem_wr_o  = strb.mem_wr;
    assign bclk_en_o = tick;

    AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ($past(|strb) && !(|strb))); // R9
    AST_FALL_GIVES_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(|strb) && !(|strb)) |-> done_o); // R9
endmodule

// File: tb/isa_cycle_timer_tb.sv
module isa_cycle_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_i;
    logic [7:0] bclk_cfg_i;
    logic [7:0] tim_cfg_i;
    logic       ref_tick_i;
    logic       req_i, req_io_i, req_write_i, req_wide_i;
    logic       io_rd_o, io_wr_o, mem_rd_o, mem_wr_o, bclk_en_o, done_o;

    int total = 0;
    int bad   = 0;
    int ref_period = 7;

    always #4 clk = ~clk;

    isa_cycle_timer dut_i (
        .clk_i(clk), .rst_i(rst_i), .bclk_cfg_i(bclk_cfg_i), .tim_cfg_i(tim_cfg_i),
        .ref_tick_i(ref_tick_i), .req_i(req_i), .req_io_i(req_io_i),
        .req_write_i(req_write_i), .req_wide_i(req_wide_i),
        .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .bclk_en_o(bclk_en_o), .done_o(done_o)
    );

    // op encoding: {io, write, wide}
    localparam logic [2:0] IO16_RD  = 3'b101;
    localparam logic [2:0] IO16_WR  = 3'b111;
    localparam logic [2:0] IO8_RD   = 3'b100;
    localparam logic [2:0] IO8_WR   = 3'b110;
    localparam logic [2:0] MEM16_RD = 3'b001;
    localparam logic [2:0] MEM16_WR = 3'b011;
    localparam logic [2:0] MEM8_RD  = 3'b000;

    function automatic logic [3:0] strb_vec();
        return {io_rd_o, io_wr_o, mem_rd_o, mem_wr_o};
    endfunction

    function automatic logic [3:0] exp_vec(input logic [2:0] op);
        case (op[2:1])
            2'b10:   return 4'b1000;
            2'b11:   return 4'b0100;
            2'b00:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_op(input logic [2:0] op);
        req_io_i    = op[2];
        req_write_i = op[1];
        req_wide_i  = op[0];
    endtask

    // reference tick source, driven away from the active edge
    initial begin
        int cnt = 0;
        ref_tick_i = 1'b0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1) % ref_period;
            ref_tick_i = (cnt == 0);
        end
    end

    task automatic wait_rise(input string req);
        int n = 0;
        while (strb_vec() == 4'b0000 && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk(n < 2000, req, n, 0);
    endtask

    task automatic count_pulses(input int cycles, input int exp, input string req);
        int n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bclk_en_o) n++;
        end
        chk(n == exp, req, n, exp);
    endtask

    // Two commands back to back with the request held high; measures the
    // first strobe, the low gap, and the second strobe, all in clocks.
    task automatic run_pair(input logic [2:0] op_a, input logic [2:0] op_b,
                            input logic [7:0] tim_mid,
                            input int exp_hi_a, input int exp_gap, input int exp_hi_b,
                            input string ra, input string rg, input string rb);
        int hi, gap;
        @(negedge clk);
        drive_op(op_a);
        req_i = 1'b1;
        wait_rise("R8 first strobe seen");
        chk(strb_vec() == exp_vec(op_a), "R8 strobe select A", strb_vec(), exp_vec(op_a));
        tim_cfg_i = tim_mid;
        hi = 0;
        while (strb_vec() != 4'b0000 && hi < 2000) begin hi++; @(negedge clk); end
        chk(hi == exp_hi_a, ra, hi, exp_hi_a);
        chk(done_o == 1'b1, "R9 done at fall A", done_o, 1);
        drive_op(op_b);
        gap = 0;
        while (strb_vec() == 4'b0000 && gap < 2000) begin
            gap++;
            if (gap == 2) chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
            @(negedge clk);
        end
        chk(gap == exp_gap, rg, gap, exp_gap);
        chk(strb_vec() == exp_vec(op_b), "R8 strobe select B", strb_vec(), exp_vec(op_b));
        hi = 0;
        while (strb_vec() != 4'b0000 && hi < 2000) begin hi++; @(negedge clk); end
        req_i = 1'b0;
        chk(hi == exp_hi_b, rb, hi, exp_hi_b);
        chk(done_o == 1'b1, "R9 done at fall B", done_o, 1);
        repeat (100) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_i = 1'b1; req_i = 1'b0; drive_op(3'b000);
        bclk_cfg_i = 8'h40; tim_cfg_i = 8'h01;
        repeat (4) @(negedge clk);
        chk(strb_vec() == 4'b0000, "R11 strobes low in reset", strb_vec(), 0);
        rst_i = 1'b0;
        @(negedge clk);
        chk(strb_vec() == 4'b0000 && !done_o, "R11 quiet after reset",
            {strb_vec(), done_o}, 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_bclk();
        bclk_cfg_i = 8'h40; repeat (8) @(negedge clk);
        count_pulses(40, 10, "R1 quarter rate");
        bclk_cfg_i = 8'h80; repeat (8) @(negedge clk);
        count_pulses(30, 10, "R1 third rate");
        bclk_cfg_i = 8'h00; repeat (8) @(negedge clk);
        count_pulses(70, 10, "R2 reference rate");
        bclk_cfg_i = 8'hC0; repeat (8) @(negedge clk);
        count_pulses(70, 10, "R2 reserved code uses reference");
        bclk_cfg_i = 8'h40; repeat (8) @(negedge clk);
    endtask

    task automatic t_wait16();
        tim_cfg_i = 8'h01;
        run_pair(IO16_RD, MEM16_WR, 8'h01, 12, 4, 12, "R3 16-bit 2 waits", "R7 mem after io", "R3 mem 16-bit");
        tim_cfg_i = 8'h05;
        run_pair(MEM16_RD, IO16_WR, 8'h05, 8, 4, 8, "R3 16-bit 1 wait", "R7 io after mem", "R3 io 16-bit fast");
    endtask

    task automatic t_wait8();
        tim_cfg_i = 8'h01;
        run_pair(IO8_RD, MEM8_RD, 8'h01, 24, 4, 24, "R4 8-bit 5 waits", "R7 mem after io8", "R4 mem 8-bit");
        tim_cfg_i = 8'h03;
        run_pair(IO8_WR, MEM8_RD, 8'h03, 20, 4, 20, "R4 8-bit 4 waits", "R7 mem after io8 fast", "R4 mem 8-bit fast");
    endtask

    task automatic t_rec16();
        for (int c = 0; c < 4; c++) begin
            logic [7:0] t;
            t = {c[1:0], 2'b00, 4'b0101};
            tim_cfg_i = t;
            run_pair(IO16_RD, IO16_WR, t, 8, 4 * (5 - c), 8,
                     "R3 io16 len", "R5 16-bit recovery gap", "R3 io16 len second");
        end
    endtask

    task automatic t_rec8();
        int n8 [4] = '{8, 5, 4, 3};
        for (int c = 0; c < 4; c++) begin
            logic [7:0] t;
            t = {2'b00, c[1:0], 4'b0011};
            tim_cfg_i = t;
            run_pair(IO8_WR, IO8_RD, t, 20, 4 * n8[c], 20,
                     "R4 io8 len", "R6 8-bit recovery gap", "R4 io8 len second");
        end
    endtask

    task automatic t_latch();
        tim_cfg_i = 8'h01;
        run_pair(IO8_WR, IO8_WR, 8'h33, 24, 32, 20,
                 "R10 length kept after change", "R10 gap kept after change", "R10 new setting used next");
    endtask

    task automatic t_other_clocks();
        bclk_cfg_i = 8'h00; tim_cfg_i = 8'h01; repeat (20) @(negedge clk);
        run_pair(IO16_RD, MEM16_RD, 8'h01, 21, 7, 21, "R2 ref-paced length", "R7 ref-paced mem gap", "R2 ref-paced mem");
        bclk_cfg_i = 8'h80; repeat (20) @(negedge clk);
        run_pair(IO16_WR, IO16_RD, 8'h01, 9, 15, 9, "R1 third-rate length", "R5 third-rate gap", "R1 third-rate second");
        bclk_cfg_i = 8'h40;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bclk();
        t_wait16();
        t_wait8();
        t_rec16();
        t_rec8();
        t_latch();
        t_other_clocks();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule